// File: doc/BRIEF.md
# Reference-Selectable Decade Time Base

This block is the time base of a digital counter. It takes a 5 MHz internal reference and divides it by five to make 1 MHz, or it takes an already shaped external reference instead. The chosen reference passes through a gate that is open only while an internal-timing flag is high. A chain of seven decimal counters then counts the gated reference, each decade stepping the next when it wraps. A preset input loads the chain to 9999990. From that value only ten gated events are needed before a carry ripples through every decade and the most significant decade output falls.

All inputs are sampled by one system clock. That clock runs at least four times faster than the fastest reference. Edges on the reference lines are found by comparing each sample with the one before, and they drive count enables, so the block has no derived clocks. A 1 MHz monitor output copies the prescaler while the internal reference is in use. All seven BCD digits are brought out.

Top module: `decade_timebase`

## Requirements
- R1: The prescaler steps once on each high-to-low transition of `ref_5m`, cycling through counts 0 to 4. Its output is high for counts 3 and 4 and low for counts 0 to 2.
- R2: While `ext_sel` is high, the prescaler is held at count 0 and its output is low. After `ext_sel` returns low, it resumes counting from 0.
- R3: `mon_1m` equals the prescaler output while `ext_sel` is low, and is low while `ext_sel` is high.
- R4: `gated_ref` is the NAND of the selected reference and `internal_en`. The selected reference is `ext_ref` when `ext_sel` is high and the prescaler output otherwise. While `internal_en` is low, the digits do not change, except on a preset.
- R5: Each decade holds a BCD value from 0 to 9. Decade i sits at `digits[4*i+3:4*i]`, and decade 0 is the least significant.
- R6: Decade 0 advances once for each high-to-low transition of `gated_ref`. Decade i, for i greater than 0, advances in the same clock cycle that decade i-1 wraps from 9 to 0. Together the digits count the gated events modulo 10,000,000.
- R7: A high `chain_reset` at a clock edge, or `rst_n` low, loads decade 0 with 0 and decades 1 to 6 with 9 (digits 28'h9999990). A preset takes priority over counting. `rst_n` low also clears the prescaler.
- R8: `decade_out[i]` is high exactly when decade i holds 8 or 9. `gate_timing` equals `decade_out[6]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_5m | input | 1 | 5 MHz internal reference, sampled |
| ext_ref | input | 1 | Shaped external reference, sampled |
| ext_sel | input | 1 | High selects the external reference and clears the prescaler |
| internal_en | input | 1 | Internal-timing flag that opens the reference gate |
| chain_reset | input | 1 | Synchronous preset of the decade chain to 9999990 |
| mon_1m | output | 1 | 1 MHz monitor output, low in external mode |
| gated_ref | output | 1 | NAND of the selected reference and `internal_en` |
| decade_out | output | 7 | Per-decade output, high for counts 8 and 9 |
| digits | output | 28 | Seven BCD digits, decade 0 in bits 3:0 |
| gate_timing | output | 1 | Most significant decade output |

## Verification
The hardest case to reach from the ports is a carry that runs through all seven decades in one cycle, because from zero it would take ten million events. The bench loads the chain with `chain_reset` and then drives exactly ten hand-made external reference pulses, which wraps every decade at once and drops `gate_timing`. A long run of fast external pulses then exercises carries into the middle decades. Switching in and out of external mode while `ref_5m` keeps toggling checks that the prescaler restarts from 0.

// File: rtl/timebase_pkg.sv
// Shared constants and types for the decade time base.
// Assumes BCD digits of four bits each.
package timebase_pkg;
    localparam int DIGIT_W       = 4;
    localparam int BCD_TOP       = 9;
    localparam int OUT_HIGH_FROM = 8;
    typedef logic [DIGIT_W-1:0] bcd_t;
endpackage

// File: rtl/ref_prescaler.sv
// Divide-by-DIV prescaler stepped on falling edges of a sampled reference.
// Assumes the system clock samples ref_in at least twice per reference level.
// The output is high for the upper DIV/2 counts. clear holds the count at zero.
module ref_prescaler #(
    parameter int DIV = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic clear,
    output logic div_out
);
    localparam int CW      = $clog2(DIV);
    localparam int HI_FROM = DIV - DIV / 2;

    logic          ref_q;
    logic [CW-1:0] cnt;
    logic          fall;

    assign fall = ref_q & ~ref_in;

    // Keep the previous sample of the reference for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= 1'b0;
        else        ref_q <= ref_in;
    end

    // Modulo-DIV count, held at zero while cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)             cnt <= '0;
        else if (fall && cnt == CW'(DIV - 1)) cnt <= '0;
        else if (fall)                   cnt <= cnt + 1'b1;
    end

    assign div_out = (cnt >= CW'(HI_FROM));

    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DIV - 1));
    assert_step_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fall && !clear |=> cnt != $past(cnt));
    assert_clear_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !div_out);
endmodule

// File: rtl/bcd_decade.sv
// One BCD decade of the counting chain.
// Assumes adv is a one-cycle enable. load has priority over adv, and load
// and reset put PRESET into the digit.
module bcd_decade
    import timebase_pkg::*;
#(
    parameter int PRESET = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic adv,
    output bcd_t digit,
    output logic dout
);
    // Preset, wrap at nine, or step on enable.
    always_ff @(posedge clk) begin
        if (!rst_n || load)                    digit <= bcd_t'(PRESET);
        else if (adv && digit == bcd_t'(BCD_TOP)) digit <= '0;
        else if (adv)                          digit <= digit + 1'b1;
    end

    assign dout = (digit >= bcd_t'(OUT_HIGH_FROM));

    assert_digit_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        digit <= bcd_t'(BCD_TOP));
    assert_preset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> digit == bcd_t'(PRESET));
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !adv |=> $stable(digit));
    assert_fall_on_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dout) && $past(rst_n) && !$past(load) |-> $past(digit) == bcd_t'(BCD_TOP));
endmodule

// File: rtl/decade_timebase.sv
// Reference-selectable decade time base: prescaler, reference gate, decade chain.
// Assumes clk is at least four times the fastest reference. The chain steps
// on falling edges of gated_ref. Carries pass through the chain in the same cycle.
module decade_timebase
    import timebase_pkg::*;
#(
    parameter int NUM_DEC = 7,
    parameter int PRE_DIV = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ref_5m,
    input  logic                       ext_ref,
    input  logic                       ext_sel,
    input  logic                       internal_en,
    input  logic                       chain_reset,
    output logic                       mon_1m,
    output logic                       gated_ref,
    output logic [NUM_DEC-1:0]         decade_out,
    output logic [NUM_DEC*DIGIT_W-1:0] digits,
    output logic                       gate_timing
);
    logic         pre_out;
    logic         sel_ref;
    logic         gate_q;
    logic         chain_step;
    logic [NUM_DEC-1:0] adv;
    bcd_t         dig [NUM_DEC];

    ref_prescaler #(.DIV(PRE_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_in  (ref_5m),
        .clear   (ext_sel),
        .div_out (pre_out)
    );

    // Reference selection, monitor and NAND gate.
    assign sel_ref   = ext_sel ? ext_ref : pre_out;
    assign mon_1m    = ~ext_sel & pre_out;
    assign gated_ref = ~(sel_ref & internal_en);

    // Keep the previous gate level for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gated_ref;
    end

    assign chain_step = gate_q & ~gated_ref;

    for (genvar i = 0; i < NUM_DEC; i++) begin : g_dec
        if (i == 0) begin : g_first
            assign adv[i] = chain_step;
        end else begin : g_rest
            assign adv[i] = adv[i-1] & (dig[i-1] == bcd_t'(BCD_TOP));
        end
        bcd_decade #(.PRESET(i == 0 ? 0 : BCD_TOP)) u_dec (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (chain_reset),
            .adv   (adv[i]),
            .digit (dig[i]),
            .dout  (decade_out[i])
        );
        assign digits[i*DIGIT_W +: DIGIT_W] = dig[i];
    end

    assign gate_timing = decade_out[NUM_DEC-1];

    assert_gate_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !internal_en && !chain_reset |=> $stable(digits));
endmodule

// File: tb/decade_timebase_tb.sv
module decade_timebase_tb;
    localparam int PRESET_VAL = 9999990;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_5m = 1'b0, ext_ref = 1'b0, ext_sel = 1'b0;
    logic        internal_en = 1'b0, chain_reset = 1'b0;
    logic        mon_1m, gated_ref, gate_timing;
    logic [6:0]  decade_out;
    logic [27:0] digits;

    int checks = 0, errors = 0;
    bit done = 0, started = 0;
    bit p5_on = 0, ext_on = 0;
    int c5 = 0, ce = 0, ext_half = 2;

    // reference model state
    int m_pcnt = 0, m_chain = PRESET_VAL;
    bit m_r5 = 0, m_g = 0;

    always #5 clk = ~clk;

    decade_timebase u_dut (
        .clk(clk), .rst_n(rst_n), .ref_5m(ref_5m), .ext_ref(ext_ref),
        .ext_sel(ext_sel), .internal_en(internal_en), .chain_reset(chain_reset),
        .mon_1m(mon_1m), .gated_ref(gated_ref), .decade_out(decade_out),
        .digits(digits), .gate_timing(gate_timing)
    );

    function automatic bit m_sel();
        return ext_sel ? ext_ref : (m_pcnt >= 3);
    endfunction

    function automatic logic [27:0] m_digits();
        logic [27:0] r = '0;
        int v = m_chain;
        for (int i = 0; i < 7; i++) begin
            r[i*4 +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    function automatic logic [6:0] m_outs();
        logic [27:0] d = m_digits();
        logic [6:0] r;
        for (int i = 0; i < 7; i++) r[i] = (d[i*4 +: 4] >= 4'd8);
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [27:0] act, input logic [27:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Behavioural model advanced on every clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pcnt = 0; m_r5 = 0; m_g = 0; m_chain = PRESET_VAL;
        end else begin
            bit g_now, fall5, gfall;
            g_now = !(m_sel() && internal_en);
            fall5 = m_r5 && !ref_5m;
            gfall = m_g && !g_now;
            if (ext_sel) m_pcnt = 0;
            else if (fall5) m_pcnt = (m_pcnt + 1) % 5;
            if (chain_reset) m_chain = PRESET_VAL;
            else if (gfall) m_chain = (m_chain + 1) % 10000000;
            m_r5 = ref_5m;
            m_g = g_now;
        end
        started = 1;
    end

    // Per-cycle comparison on the falling edge, then reference toggling
    always @(negedge clk) begin
        if (started) begin
            logic exp_mon, exp_g;
            exp_mon = !ext_sel && (m_pcnt >= 3);
            exp_g   = !(m_sel() && internal_en);
            chk(digits === m_digits(), "R5 R6 digits", digits, m_digits());
            chk(decade_out === m_outs(), "R8 decade_out", 28'(decade_out), 28'(m_outs()));
            chk(gate_timing === m_outs()[6], "R8 gate_timing", 28'(gate_timing), 28'(m_outs()[6]));
            chk(gated_ref === exp_g, "R4 gated_ref", 28'(gated_ref), 28'(exp_g));
            chk(mon_1m === exp_mon, "R1 R2 R3 mon_1m", 28'(mon_1m), 28'(exp_mon));
        end
        #1;
        if (p5_on) begin
            c5++;
            if (c5 >= 2) begin ref_5m = ~ref_5m; c5 = 0; end
        end
        if (ext_on) begin
            ce++;
            if (ce >= ext_half) begin ext_ref = ~ext_ref; ce = 0; end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic ext_pulse();
        ext_ref = 1'b1; wait_cyc(2);
        ext_ref = 1'b0; wait_cyc(2);
    endtask

    initial begin
        logic [27:0] snap;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        #1;
        chk(digits === 28'h9999990, "R7 reset digits", digits, 28'h9999990);
        chk(decade_out === 7'b1111110, "R8 reset decade_out", 28'(decade_out), 28'h7E);
        chk(mon_1m === 1'b0, "R3 reset mon", 28'(mon_1m), 28'h0);

        // internal reference, gate open
        internal_en = 1'b1; p5_on = 1;
        wait_cyc(400);

        // gate closed: chain frozen
        internal_en = 1'b0;
        wait_cyc(2);
        snap = digits;
        wait_cyc(200);
        #1;
        chk(digits === snap, "R4 frozen while gate closed", digits, snap);

        // external reference, fast pulses, prescaler still toggling
        ext_sel = 1'b1; internal_en = 1'b1; ext_on = 1; ext_half = 2;
        wait_cyc(4000);
        #1;
        chk(mon_1m === 1'b0, "R2 monitor low in external mode", 28'(mon_1m), 28'h0);

        // preset then exactly ten events: full carry
        ext_on = 0; ext_ref = 1'b0;
        wait_cyc(3);
        chain_reset = 1'b1; wait_cyc(1);
        chain_reset = 1'b0; wait_cyc(1);
        #1;
        chk(digits === 28'h9999990, "R7 chain preset", digits, 28'h9999990);
        for (int k = 0; k < 9; k++) ext_pulse();
        #1;
        chk(digits === 28'h9999999, "R6 nine events", digits, 28'h9999999);
        chk(gate_timing === 1'b1, "R8 gate_timing high before wrap", 28'(gate_timing), 28'h1);
        ext_pulse();
        #1;
        chk(digits === 28'h0000000, "R6 full carry wrap", digits, 28'h0);
        chk(gate_timing === 1'b0, "R8 gate_timing after wrap", 28'(gate_timing), 28'h0);
        ext_pulse();
        #1;
        chk(digits === 28'h0000001, "R6 step after wrap", digits, 28'h1);

        // preset while events keep arriving
        ext_on = 1; ext_half = 3;
        wait_cyc(50);
        chain_reset = 1'b1; wait_cyc(4);
        chain_reset = 1'b0;
        wait_cyc(100);

        // back to internal reference: prescaler restarts from zero
        ext_on = 0; ext_ref = 1'b0; ext_sel = 1'b0;
        wait_cyc(600);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        summary();
    end
endmodule